// File: doc/BRIEF.md
# Message and Doorbell Interrupt Unit

This block is a mailbox between a host-side bus master and a local processor. Each side has its own simple register port with a word address, a write strobe with write data, and a read strobe with registered read data one cycle later. Traffic flows in two directions. Inbound carries words from the host to the local processor. Outbound carries words from the local processor to the host. Each direction has two 32-bit message words, one doorbell word, a status byte and a mask byte. The receiving side owns the status and the mask. Each side has one interrupt output. It is raised when the receiving side's status, filtered by its mask, has any bit set.

Both ports use the same local view, so firmware on either side runs the same code. Each side has a transmit half (the message words and doorbell it writes) and a receive half (the message words it reads, the doorbell it drains, and its own status and mask). Reading the receive doorbell hands over its bits and empties it. Reading the receive status returns only the enabled bits and clears those bits.

Top module: `mdu_mailbox_unit`

Word offsets, the same on both ports (the low three address bits): 0 and 1 are transmit message 0 and 1 (read/write); 2 and 3 are receive message 0 and 1 (read only); 4 is the transmit doorbell (write ORs in, read returns it without clearing); 5 is the receive doorbell (read returns and clears); 6 is the receive status (read returns masked status and clears); 7 is the receive mask (read/write). The transmit direction of the host is inbound and that of the local side is outbound.

## Requirements
- R1: After reset every message, doorbell, status and mask register holds zero, both read data outputs are zero and both interrupt outputs are low.
- R2: A write to transmit message n (offset 0 or 1) stores the word. The writer reads it back at the same offset, and the other side reads it at offset 2+n. Read data appears the cycle after the read strobe and holds until the next read.
- R3: A write to transmit message n sets status bit n (bit 0 for message 0, bit 1 for message 1) of the direction written, on both directions.
- R4: A write to the transmit doorbell ORs the data into it, so earlier bits are kept. A write whose data carries a doorbell bit sets status bit 3 of that direction.
- R5: A read of the receive doorbell (offset 5) returns its contents and clears it. Bits written by the other side in the same cycle are kept for the next read.
- R6: On the inbound doorbell only, data bit DATA_W-1 is a machine-check request. It sets inbound status bit 4. It sets bit 3 only if some other data bit is set. On the outbound doorbell every bit counts as a doorbell bit.
- R7: A status read (offset 6) returns the status ANDed with the mask, zero-extended, and clears exactly the bits it returns. Masked-off bits stay pending and appear once enabled.
- R8: Only mask bits with a source can be written: bits 0, 1, 3 and 4 inbound (0x1B) and bits 0, 1 and 3 outbound (0x0B). Doorbell enable code 1 maps to mask bit 3 and machine-check code 2 to bit 4. All other mask and status bits read as zero.
- R9: The host interrupt is the registered OR of outbound status ANDed with outbound mask. The local interrupt is the same for inbound. Each follows the clock edge that changes its status or mask.
- R10: Writes to read-only offsets (2, 3, 5, 6) change nothing. Any access whose address bits above bit 2 are not all zero is ignored, and its read returns zero.
- R11: When a status bit is set and read-cleared in the same cycle, the read returns it and it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | ADDR_W | Host word address |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Host read data, one cycle after the strobe |
| localAddr | input | ADDR_W | Local word address |
| localWrEn | input | 1 | Local write strobe |
| localRdEn | input | 1 | Local read strobe |
| localWrData | input | DATA_W | Local write data |
| localRdData | output | DATA_W | Local read data, one cycle after the strobe |
| hostIrq | output | 1 | Interrupt toward the host (outbound events) |
| localIrq | output | 1 | Interrupt toward the local processor (inbound events) |

## Verification
The bench builds the block with DATA_W = 32 and ADDR_W = 4. The wide data puts the machine-check flag at bit 31, alongside 31 ordinary doorbell bits. The spare address bit makes out-of-window addresses 8 to 15 reachable, so accesses that must be ignored are exercised on both ports. Random traffic drives both ports in the same cycles, which reaches the cases where one side sets bits while the other drains them.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam int SEL_W  = 3;
  localparam int STAT_W = 8;
  localparam int MSG_N  = 2;

  // Per-side word offsets (low address bits)
  localparam logic [SEL_W-1:0] OFS_TX_MSG0 = 3'd0;
  localparam logic [SEL_W-1:0] OFS_TX_MSG1 = 3'd1;
  localparam logic [SEL_W-1:0] OFS_RX_MSG0 = 3'd2;
  localparam logic [SEL_W-1:0] OFS_RX_MSG1 = 3'd3;
  localparam logic [SEL_W-1:0] OFS_TX_DB   = 3'd4;
  localparam logic [SEL_W-1:0] OFS_RX_DB   = 3'd5;
  localparam logic [SEL_W-1:0] OFS_RX_STAT = 3'd6;
  localparam logic [SEL_W-1:0] OFS_RX_MASK = 3'd7;

  // Status bit positions
  localparam int ST_DB = 3;
  localparam int ST_MC = 4;

  // Implemented status/mask bits per direction (0 = inbound, 1 = outbound)
  localparam logic [STAT_W-1:0] IN_VALID  = 8'h1B;
  localparam logic [STAT_W-1:0] OUT_VALID = 8'h0B;

  typedef enum logic {SIDE_HOST = 1'b0, SIDE_LOCAL = 1'b1} side_e;

  // Strobes from decode to datapath, one per side
  typedef struct packed {
    logic [MSG_N-1:0] txMsgWr;
    logic             txDbWr;
    logic             rxMaskWr;
    logic             rxDbRd;
    logic             rxStatRd;
    logic             rd;
    logic             rdHit;
    logic [SEL_W-1:0] rdSel;
  } sideStb_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0]             wrEn,
  input  logic [1:0]             rdEn,
  output sideStb_t [1:0]         stb
);

  for (genvar s = 0; s < 2; s++) begin : gSide
    logic             inRange;
    logic [SEL_W-1:0] sel;
    logic             wrHit;
    logic             rdHitNow;

    if (ADDR_W > SEL_W) begin : gWide
      assign inRange = ~|addr[s][ADDR_W-1:SEL_W];
    end else begin : gNarrow
      assign inRange = 1'b1;
    end

    assign sel      = addr[s][SEL_W-1:0];
    assign wrHit    = wrEn[s] & inRange;
    assign rdHitNow = rdEn[s] & inRange;

    always_comb begin
      stb[s]            = '0;
      stb[s].txMsgWr[0] = wrHit && (sel == OFS_TX_MSG0);
      stb[s].txMsgWr[1] = wrHit && (sel == OFS_TX_MSG1);
      stb[s].txDbWr     = wrHit && (sel == OFS_TX_DB);
      stb[s].rxMaskWr   = wrHit && (sel == OFS_RX_MASK);
      stb[s].rxDbRd     = rdHitNow && (sel == OFS_RX_DB);
      stb[s].rxStatRd   = rdHitNow && (sel == OFS_RX_STAT);
      stb[s].rd         = rdEn[s];
      stb[s].rdHit      = inRange;
      stb[s].rdSel      = sel;
    end
  end

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  sideStb_t [1:0]         stb,
  input  logic [1:0][DATA_W-1:0] wrData,
  output logic [1:0][DATA_W-1:0] rdData,
  output logic [1:0]             irq
);

  localparam logic [DATA_W-1:0] MC_BIT = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int PAD_W = DATA_W - STAT_W;

  // Direction d is written by side d and serviced by side 1-d
  for (genvar d = 0; d < 2; d++) begin : gDir
    localparam int RX = 1 - d;
    localparam logic [STAT_W-1:0] VALID = (d == 0) ? IN_VALID : OUT_VALID;
    localparam bit HAS_MC = (d == 0);

    logic [MSG_N-1:0][DATA_W-1:0] msgQ;
    logic [DATA_W-1:0] dbQ, dbNext, dbPlain;
    logic [STAT_W-1:0] statQ, statNext, statSet, statClr;
    logic [STAT_W-1:0] maskQ, maskNext;
    logic              irqQ;

    assign dbPlain = HAS_MC ? (wrData[d] & ~MC_BIT) : wrData[d];

    always_comb begin
      statSet = '0;
      statSet[MSG_N-1:0] = stb[d].txMsgWr;
      statSet[ST_DB] = stb[d].txDbWr & (|dbPlain);
      if (HAS_MC) statSet[ST_MC] = stb[d].txDbWr & wrData[d][DATA_W-1];
      statClr  = stb[RX].rxStatRd ? (statQ & maskQ) : '0;
      statNext = (statQ & ~statClr) | statSet;
      maskNext = stb[RX].rxMaskWr ? (wrData[RX][STAT_W-1:0] & VALID) : maskQ;
      dbNext   = (stb[RX].rxDbRd ? '0 : dbQ) | (stb[d].txDbWr ? wrData[d] : '0);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dbQ   <= '0;
        statQ <= '0;
        maskQ <= '0;
        irqQ  <= 1'b0;
      end else begin
        dbQ   <= dbNext;
        statQ <= statNext;
        maskQ <= maskNext;
        irqQ  <= |(statNext & maskNext);
      end
    end

    for (genvar m = 0; m < MSG_N; m++) begin : gMsg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                msgQ[m] <= '0;
        else if (stb[d].txMsgWr[m]) msgQ[m] <= wrData[d];
      end
    end

    assign irq[RX] = irqQ;
  end

  // Read path per side: transmit direction s, receive direction 1-s
  for (genvar s = 0; s < 2; s++) begin : gRead
    localparam int TX = s;
    localparam int RX = 1 - s;
    logic [DATA_W-1:0] rdMux, rdQ;

    always_comb begin
      unique case (stb[s].rdSel)
        OFS_TX_MSG0: rdMux = gDir[TX].msgQ[0];
        OFS_TX_MSG1: rdMux = gDir[TX].msgQ[1];
        OFS_RX_MSG0: rdMux = gDir[RX].msgQ[0];
        OFS_RX_MSG1: rdMux = gDir[RX].msgQ[1];
        OFS_TX_DB:   rdMux = gDir[TX].dbQ;
        OFS_RX_DB:   rdMux = gDir[RX].dbQ;
        OFS_RX_STAT: rdMux = {{PAD_W{1'b0}}, gDir[RX].statQ & gDir[RX].maskQ};
        default:     rdMux = {{PAD_W{1'b0}}, gDir[RX].maskQ};
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          rdQ <= '0;
      else if (stb[s].rd) rdQ <= stb[s].rdHit ? rdMux : '0;
    end

    assign rdData[s] = rdQ;
  end

endmodule

// File: rtl/mdu_mailbox_unit.sv
module mdu_mailbox_unit
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic              localWrEn,
  input  logic              localRdEn,
  input  logic [DATA_W-1:0] localWrData,
  output logic [DATA_W-1:0] localRdData,
  output logic              hostIrq,
  output logic              localIrq
);

  logic [1:0][ADDR_W-1:0] addrV;
  logic [1:0]             wrV, rdV, irqV;
  logic [1:0][DATA_W-1:0] wdV, rdDataV;
  sideStb_t [1:0]         stb;

  assign addrV[SIDE_HOST]  = hostAddr;
  assign addrV[SIDE_LOCAL] = localAddr;
  assign wrV   = {localWrEn, hostWrEn};
  assign rdV   = {localRdEn, hostRdEn};
  assign wdV[SIDE_HOST]  = hostWrData;
  assign wdV[SIDE_LOCAL] = localWrData;

  mdu_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .addr (addrV),
    .wrEn (wrV),
    .rdEn (rdV),
    .stb  (stb)
  );

  mdu_datapath #(.DATA_W(DATA_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wdV),
    .rdData (rdDataV),
    .irq    (irqV)
  );

  assign hostRdData  = rdDataV[SIDE_HOST];
  assign localRdData = rdDataV[SIDE_LOCAL];
  assign hostIrq     = irqV[SIDE_HOST];
  assign localIrq    = irqV[SIDE_LOCAL];

endmodule

// File: rtl/mdu_mailbox_unit_chk.sv
module mdu_mailbox_unit_chk
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostWrEn,
  input logic              hostRdEn,
  input logic [DATA_W-1:0] hostWrData,
  input logic [DATA_W-1:0] hostRdData,
  input logic [ADDR_W-1:0] localAddr,
  input logic              localWrEn,
  input logic              localRdEn,
  input logic [DATA_W-1:0] localWrData,
  input logic [DATA_W-1:0] localRdData,
  input logic              hostIrq,
  input logic              localIrq
);

  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_RX_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_RX_STAT);
  localparam logic [ADDR_W-1:0] A_RXDB = ADDR_W'(OFS_RX_DB);
  localparam logic [DATA_W-1:0] IN_KEEP  = DATA_W'(IN_VALID);
  localparam logic [DATA_W-1:0] OUT_KEEP = DATA_W'(OUT_VALID);

  // R1: while reset is held, outputs are quiet one edge later
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!hostIrq && !localIrq && hostRdData == '0 && localRdData == '0));

  // R2: read data holds when no read strobe
  a_r2_host_hold: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdEn |=> $stable(hostRdData));
  a_r2_local_hold: assert property (@(posedge clk) disable iff (!rstN)
    !localRdEn |=> $stable(localRdData));

  // R9: clearing the whole mask drops the interrupt on the next edge
  a_r9_host_mask_off: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == A_MASK && hostWrData[STAT_W-1:0] == '0) |=> !hostIrq);
  a_r9_local_mask_off: assert property (@(posedge clk) disable iff (!rstN)
    (localWrEn && localAddr == A_MASK && localWrData[STAT_W-1:0] == '0) |=> !localIrq);

  // R8: reserved mask bits read as zero
  a_r8_host_mask_rsv: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostAddr == A_MASK) |=> ((hostRdData & ~OUT_KEEP) == '0));
  a_r8_local_mask_rsv: assert property (@(posedge clk) disable iff (!rstN)
    (localRdEn && localAddr == A_MASK) |=> ((localRdData & ~IN_KEEP) == '0));

  // R7: status reads carry only implemented bits
  a_r7_host_stat_rsv: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostAddr == A_STAT) |=> ((hostRdData & ~OUT_KEEP) == '0));
  a_r7_local_stat_rsv: assert property (@(posedge clk) disable iff (!rstN)
    (localRdEn && localAddr == A_STAT) |=> ((localRdData & ~IN_KEEP) == '0));

  // R10: out-of-window reads return zero
  a_r10_host_far_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && (hostAddr >> SEL_W) != '0) |=> (hostRdData == '0));
  a_r10_local_far_zero: assert property (@(posedge clk) disable iff (!rstN)
    (localRdEn && (localAddr >> SEL_W) != '0) |=> (localRdData == '0));

  // R5: back-to-back doorbell drains with no write in between give zero
  a_r5_local_db_drained: assert property (@(posedge clk) disable iff (!rstN)
    (localRdEn && localAddr == A_RXDB && !hostWrEn) ##1 (localRdEn && localAddr == A_RXDB)
      |=> (localRdData == '0));

endmodule

bind mdu_mailbox_unit mdu_mailbox_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN),
  .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .hostWrData(hostWrData), .hostRdData(hostRdData),
  .localAddr(localAddr), .localWrEn(localWrEn), .localRdEn(localRdEn),
  .localWrData(localWrData), .localRdData(localRdData),
  .hostIrq(hostIrq), .localIrq(localIrq)
);

// File: tb/mdu_mailbox_unit_test.sv
`timescale 1ns/1ps
module mdu_mailbox_unit_test;

  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] hostAddr = '0, localAddr = '0;
  logic          hostWrEn = 1'b0, hostRdEn = 1'b0, localWrEn = 1'b0, localRdEn = 1'b0;
  logic [DW-1:0] hostWrData = '0, localWrData = '0;
  logic [DW-1:0] hostRdData, localRdData;
  logic          hostIrq, localIrq;

  mdu_mailbox_unit #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .localAddr(localAddr), .localWrEn(localWrEn), .localRdEn(localRdEn),
    .localWrData(localWrData), .localRdData(localRdData),
    .hostIrq(hostIrq), .localIrq(localIrq)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference state: index 0 = inbound (host writes), 1 = outbound (local writes)
  logic [DW-1:0] mMsg [2][2];
  logic [DW-1:0] mDb [2];
  logic [7:0]    mStat [2];
  logic [7:0]    mMask [2];
  logic [DW-1:0] mRd [2];
  logic          mIrq [2];

  function automatic logic [7:0] validOf(int d);
    return (d == 0) ? 8'h1B : 8'h0B;
  endfunction

  function automatic logic [DW-1:0] readVal(int s, logic [AW-1:0] a);
    if (a > 7) return '0;
    case (a[2:0])
      3'd0: return mMsg[s][0];
      3'd1: return mMsg[s][1];
      3'd2: return mMsg[1-s][0];
      3'd3: return mMsg[1-s][1];
      3'd4: return mDb[s];
      3'd5: return mDb[1-s];
      3'd6: return {24'd0, mStat[1-s] & mMask[1-s]};
      default: return {24'd0, mMask[1-s]};
    endcase
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int d = 0; d < 2; d++) begin
      mMsg[d][0] = '0; mMsg[d][1] = '0; mDb[d] = '0;
      mStat[d] = '0; mMask[d] = '0; mRd[d] = '0; mIrq[d] = 1'b0;
    end
  endtask

  // One access cycle on both ports, then compare at the following negedge
  task automatic step(string tag,
                      bit hw, bit hr, logic [AW-1:0] ha, logic [DW-1:0] hd,
                      bit lw, bit lr, logic [AW-1:0] la, logic [DW-1:0] ld);
    bit w[2], r[2];
    logic [AW-1:0] a[2];
    logic [DW-1:0] dt[2];
    logic [7:0] nStat[2], nMask[2];
    logic [DW-1:0] nDb[2];
    w[0] = hw; r[0] = hr; a[0] = ha; dt[0] = hd;
    w[1] = lw; r[1] = lr; a[1] = la; dt[1] = ld;
    hostWrEn = hw; hostRdEn = hr; hostAddr = ha; hostWrData = hd;
    localWrEn = lw; localRdEn = lr; localAddr = la; localWrData = ld;
    for (int s = 0; s < 2; s++) if (r[s]) mRd[s] = readVal(s, a[s]);
    for (int d = 0; d < 2; d++) begin
      int rx;
      logic [7:0] set, clr;
      logic [DW-1:0] plain;
      rx = 1 - d;
      set = '0;
      clr = (r[rx] && a[rx] == 6) ? (mStat[d] & mMask[d]) : 8'h00;
      nDb[d] = (r[rx] && a[rx] == 5) ? '0 : mDb[d];
      if (w[d] && a[d] < 8) begin
        case (a[d][2:0])
          3'd0: begin set[0] = 1'b1; mMsg[d][0] = dt[d]; end
          3'd1: begin set[1] = 1'b1; mMsg[d][1] = dt[d]; end
          3'd4: begin
            plain = (d == 0) ? (dt[d] & 32'h7FFF_FFFF) : dt[d];
            set[3] = (plain != 0);
            if (d == 0) set[4] = dt[d][31];
            nDb[d] = nDb[d] | dt[d];
          end
          default: ;
        endcase
      end
      nStat[d] = (mStat[d] & ~clr) | set;
      nMask[d] = (w[rx] && a[rx] == 7) ? (dt[rx][7:0] & validOf(d)) : mMask[d];
    end
    for (int d = 0; d < 2; d++) begin
      mStat[d] = nStat[d]; mMask[d] = nMask[d]; mDb[d] = nDb[d];
      mIrq[1-d] = |(nStat[d] & nMask[d]);
    end
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0; hostRdEn = 1'b0; localWrEn = 1'b0; localRdEn = 1'b0;
    check(tag, "hostRdData", hostRdData, mRd[0]);
    check(tag, "localRdData", localRdData, mRd[1]);
    check({tag, " R9"}, "hostIrq", DW'(hostIrq), DW'(mIrq[0]));
    check({tag, " R9"}, "localIrq", DW'(localIrq), DW'(mIrq[1]));
  endtask

  task automatic hostOp(string tag, bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    step(tag, wr, !wr, a, d, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic localOp(string tag, bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    step(tag, 1'b0, 1'b0, '0, '0, wr, !wr, a, d);
  endtask

  function automatic logic [DW-1:0] randData();
    int k;
    k = $urandom_range(0, 7);
    case (k)
      0: return '0;
      1: return 32'h8000_0000;
      2: return 32'h8000_0000 | DW'($urandom_range(1, 15));
      3: return DW'($urandom_range(0, 255));
      default: return $urandom();
    endcase
  endfunction

  function automatic logic [AW-1:0] randAddr();
    if ($urandom_range(0, 9) == 0) return AW'($urandom_range(8, 15));
    return AW'($urandom_range(0, 7));
  endfunction

  initial begin : watchdog
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", "hostRdData", hostRdData, '0);
    check("R1", "localRdData", localRdData, '0);
    check("R1", "hostIrq", DW'(hostIrq), '0);
    check("R1", "localIrq", DW'(localIrq), '0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      hostOp("R1", 1'b0, AW'(i), '0);
      localOp("R1", 1'b0, AW'(i), '0);
    end

    // R2: message words in both directions
    hostOp("R2", 1'b1, 4'd0, 32'hA5A5_0001);
    hostOp("R2", 1'b1, 4'd1, 32'h5A5A_0002);
    localOp("R2", 1'b0, 4'd2, '0);
    localOp("R2", 1'b0, 4'd3, '0);
    hostOp("R2", 1'b0, 4'd1, '0);
    localOp("R2", 1'b1, 4'd0, 32'hDEAD_BEEF);
    localOp("R2", 1'b1, 4'd1, 32'h0BAD_F00D);
    hostOp("R2", 1'b0, 4'd2, '0);
    hostOp("R2", 1'b0, 4'd3, '0);
    step("R2", 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);

    // R3: message status bits and the interrupt toward each side
    localOp("R3", 1'b1, 4'd7, 32'h0000_0003);
    hostOp("R3", 1'b1, 4'd0, 32'h1111_1111);
    localOp("R3", 1'b0, 4'd6, '0);
    hostOp("R3", 1'b1, 4'd7, 32'h0000_0002);
    localOp("R3", 1'b1, 4'd1, 32'h2222_2222);
    hostOp("R3", 1'b0, 4'd6, '0);
    hostOp("R3", 1'b0, 4'd6, '0);

    // R4 and R5: doorbell OR-in and drain
    localOp("R4", 1'b1, 4'd7, 32'h0000_0008);
    hostOp("R4", 1'b1, 4'd4, 32'h0000_0001);
    hostOp("R4", 1'b1, 4'd4, 32'h0000_0004);
    hostOp("R4", 1'b0, 4'd4, '0);
    localOp("R5", 1'b0, 4'd5, '0);
    localOp("R5", 1'b0, 4'd5, '0);
    hostOp("R5", 1'b1, 4'd4, 32'h0000_0100);
    step("R5", 1'b1, 1'b0, 4'd4, 32'h0000_0010, 1'b0, 1'b1, 4'd5, '0);
    localOp("R5", 1'b0, 4'd5, '0);
    localOp("R4", 1'b0, 4'd6, '0);

    // R6: machine-check flag on the inbound doorbell only
    localOp("R6", 1'b1, 4'd7, 32'h0000_0018);
    hostOp("R6", 1'b1, 4'd4, 32'h8000_0000);
    localOp("R6", 1'b0, 4'd6, '0);
    hostOp("R6", 1'b1, 4'd4, 32'h8000_0002);
    localOp("R6", 1'b0, 4'd6, '0);
    hostOp("R6", 1'b1, 4'd7, 32'h0000_00FF);
    localOp("R6", 1'b1, 4'd4, 32'h8000_0000);
    hostOp("R6", 1'b0, 4'd6, '0);

    // R7: masked-off status stays pending
    localOp("R7", 1'b1, 4'd7, 32'h0000_0000);
    hostOp("R7", 1'b1, 4'd1, 32'h7777_7777);
    localOp("R7", 1'b0, 4'd6, '0);
    localOp("R7", 1'b1, 4'd7, 32'h0000_0002);
    localOp("R7", 1'b0, 4'd6, '0);

    // R8: mask write keeps only implemented bits
    localOp("R8", 1'b1, 4'd7, 32'hFFFF_FFFF);
    localOp("R8", 1'b0, 4'd7, '0);
    hostOp("R8", 1'b1, 4'd7, 32'hFFFF_FFFF);
    hostOp("R8", 1'b0, 4'd7, '0);

    // R10: read-only offsets and far addresses are ignored
    hostOp("R10", 1'b1, 4'd2, 32'hCAFE_0000);
    hostOp("R10", 1'b1, 4'd5, 32'hCAFE_0001);
    hostOp("R10", 1'b1, 4'd6, 32'hCAFE_0002);
    hostOp("R10", 1'b0, 4'd2, '0);
    hostOp("R10", 1'b1, 4'd8, 32'hCAFE_0003);
    hostOp("R10", 1'b1, 4'd12, 32'hCAFE_0004);
    hostOp("R10", 1'b0, 4'd0, '0);
    localOp("R10", 1'b0, 4'd8, '0);
    hostOp("R10", 1'b0, 4'd15, '0);

    // R11: set and read-clear of the same status bit in one cycle
    localOp("R11", 1'b1, 4'd7, 32'h0000_0001);
    hostOp("R11", 1'b1, 4'd0, 32'h0000_00AA);
    step("R11", 1'b1, 1'b0, 4'd0, 32'h0000_00BB, 1'b0, 1'b1, 4'd6, '0);
    localOp("R11", 1'b0, 4'd6, '0);
    localOp("R11", 1'b0, 4'd6, '0);

    // Random traffic on both ports at once
    for (int i = 0; i < 4000; i++) begin
      bit hw, hr, lw, lr;
      hw = ($urandom_range(0, 2) == 0);
      hr = ($urandom_range(0, 2) == 0);
      lw = ($urandom_range(0, 2) == 0);
      lr = ($urandom_range(0, 2) == 0);
      step("R2/R7 random", hw, hr, randAddr(), randData(), lw, lr, randAddr(), randData());
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule